// File: doc/BRIEF.md
# Per-Flow Traffic Counter Readout Engine

This block keeps a byte counter and a packet counter for every flow entry in a table. Traffic logic reports each forwarded packet on an update port as an entry index and a byte length. If counting is enabled globally and the entry's own counting flag is set, the packet adds its length to the entry's byte count and one to its packet count. Each counter saturates at the width that the current layout allows.

Software reads an entry through a register-style control write. It writes an index and a start bit in the same cycle, and the start bit then reads back as busy. After a fixed two-cycle latency the engine has copied the entry's counters into four 32-bit result words and the busy bit drops. The counters can be packed in either of two layouts. In the wide layout each counter has 64 bits. In the narrow layout the byte counter has 48 bits and the packet counter has 40 bits, and the two share a word. An optional read-clear setting zeroes the entry when its counters are captured, so successive reads return deltas.

Top module: `flow_stat_reader`

## Requirements
- R1: After reset `ctl_busy` is 0, all four result words are 0, all counters are 0 and every entry's counting flag is clear.
- R2: Suppose `ctl_we` and `ctl_start` are both 1 on a rising edge while `ctl_busy` is 0. That edge accepts a read of `ctl_idx`. `ctl_busy` is then 1 for exactly two cycles. The result words take their new values on the same edge at which `ctl_busy` returns to 0.
- R3: A start written while `ctl_busy` is 1 is ignored. The read already in progress keeps its index and its timing. A control write with `ctl_start` at 0 starts nothing.
- R4: In wide layout (`cfg_narrow` = 0) the result words are arranged as follows. Word 0 holds byte count bits 31:0 and word 1 holds bits 63:32. Word 2 holds packet count bits 31:0 and word 3 holds bits 63:32.
- R5: In narrow layout (`cfg_narrow` = 1) the byte count is presented as 48 bits. Its bits 31:0 are in word 0 and bits 47:32 are in word 1 bits 15:0. The packet count is presented as 40 bits. Its bits 15:0 are in word 1 bits 31:16 and bits 39:16 are in word 2 bits 23:0. Word 2 bits 31:24 and all of word 3 are 0. A value too large for its field is presented as all ones.
- R6: An update is counted only if `upd_valid`, `cfg_count_en` and the flag of entry `upd_idx` are all 1. A counted update adds `upd_len` to the byte count and 1 to the packet count of that entry only.
- R7: With `cfg_read_clear` = 1 a read zeroes the entry's counters on the edge that captures them, so the next read returns only what has been counted since. With `cfg_read_clear` = 0 a read leaves the counters unchanged.
- R8: Suppose a counted update hits the entry being cleared by a read on the capture edge. The read returns the values from before that update, and the update then becomes the entry's new content, so no update is lost.
- R9: The byte and packet counters saturate instead of wrapping. The limit for each is the smaller of its storage width (`BYTE_W`, `PKT_W`) and its field width in the active layout (48 bits for bytes and 40 bits for packets in narrow layout, the storage width in wide layout).
- R10: Writing `flag_we` = 1 sets the counting flag of entry `flag_idx` to `flag_set`. An entry whose flag is 0 keeps its counters unchanged under updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_count_en | input | 1 | Global counting enable |
| cfg_read_clear | input | 1 | Zero an entry when it is read |
| cfg_narrow | input | 1 | 1 selects the 48/40-bit layout, 0 selects the 64/64-bit layout |
| flag_we | input | 1 | Write strobe for a per-entry counting flag |
| flag_idx | input | IDX_W | Entry whose flag is written |
| flag_set | input | 1 | New flag value |
| upd_valid | input | 1 | Packet report valid |
| upd_idx | input | IDX_W | Entry the packet belongs to |
| upd_len | input | LEN_W | Packet length in bytes |
| ctl_we | input | 1 | Control register write strobe |
| ctl_idx | input | IDX_W | Entry to read |
| ctl_start | input | 1 | Start bit of the control write |
| ctl_busy | output | 1 | Start bit readback, 1 while a read is in progress |
| res_word0 | output | 32 | Result word 0 |
| res_word1 | output | 32 | Result word 1 |
| res_word2 | output | 32 | Result word 2 |
| res_word3 | output | 32 | Result word 3 |

## Verification
Counter updates take effect on the edge where they are sampled. A read accepted on edge E captures the entry's counters on E+1, where a read-clear also takes effect, and presents the result words on E+2. At that same edge `ctl_busy` falls. A behavioural model in the bench applies the same edge rules and is compared with `ctl_busy` and the four words at every falling clock edge. Each directed read drives its start, checks busy on the two following falling edges, and checks the literal expected words on the third falling edge. Collision and ignored-start stimulus is placed on the falling edge just before the capture edge.

// File: rtl/flow_stat_pkg.sv
package flow_stat_pkg;

  localparam int WORD_W        = 32;
  localparam int NARROW_BYTE_W = 48;
  localparam int NARROW_PKT_W  = 40;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t w3;
    word_t w2;
    word_t w1;
    word_t w0;
  } res_words_t;

  // mask with the n lowest bits set
  function automatic logic [63:0] low_ones(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [63:0] clip_to(input logic [63:0] v, input int n);
    logic [63:0] lim;
    lim = low_ones(n);
    return (v > lim) ? lim : v;
  endfunction

  // arrange a byte / packet pair into the four result words
  function automatic res_words_t pack_counts(input logic narrow,
                                             input logic [63:0] b,
                                             input logic [63:0] p);
    res_words_t r;
    logic [63:0] cb;
    logic [63:0] cp;
    cb = clip_to(b, NARROW_BYTE_W);
    cp = clip_to(p, NARROW_PKT_W);
    if (narrow) begin
      r.w0 = cb[31:0];
      r.w1 = {cp[15:0], cb[47:32]};
      r.w2 = {8'h00, cp[39:16]};
      r.w3 = '0;
    end else begin
      r.w0 = b[31:0];
      r.w1 = b[63:32];
      r.w2 = p[31:0];
      r.w3 = p[63:32];
    end
    return r;
  endfunction

endpackage

// File: rtl/flow_cnt_bank.sv
module flow_cnt_bank
  import flow_stat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LEN_W   = 16,
  parameter int BYTE_W  = 64,
  parameter int PKT_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              narrow,
  input  logic              flag_we,
  input  logic [IDX_W-1:0]  flag_idx,
  input  logic              flag_set,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [LEN_W-1:0]  upd_len,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_bytes,
  output logic [PKT_W-1:0]  rd_pkts
);

  localparam int BSUM_W = BYTE_W + 1;
  localparam int PSUM_W = PKT_W + 1;
  localparam int BYTE_NW = (BYTE_W < NARROW_BYTE_W) ? BYTE_W : NARROW_BYTE_W;
  localparam int PKT_NW  = (PKT_W < NARROW_PKT_W) ? PKT_W : NARROW_PKT_W;
  localparam logic [BYTE_W-1:0] BYTE_NARROW_LIM = BYTE_W'(low_ones(BYTE_NW));
  localparam logic [PKT_W-1:0]  PKT_NARROW_LIM  = PKT_W'(low_ones(PKT_NW));

  logic [BYTE_W-1:0] bytes_q [ENTRIES];
  logic [PKT_W-1:0]  pkts_q  [ENTRIES];
  logic [BYTE_W-1:0] bytes_d [ENTRIES];
  logic [PKT_W-1:0]  pkts_d  [ENTRIES];
  logic [ENTRIES-1:0] flag_q;
  logic [ENTRIES-1:0] flag_d;
  logic [ENTRIES-1:0] cnt_ce;

  logic [BYTE_W-1:0] byte_lim;
  logic [PKT_W-1:0]  pkt_lim;

  assign byte_lim = narrow ? BYTE_NARROW_LIM : '1;
  assign pkt_lim  = narrow ? PKT_NARROW_LIM  : '1;

  // next-state for every entry
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin : g_next
      logic              hit;
      logic              clr;
      logic [BYTE_W-1:0] base_b;
      logic [PKT_W-1:0]  base_p;
      logic [BSUM_W-1:0] sum_b;
      logic [PSUM_W-1:0] sum_p;
      hit    = upd_valid && count_en && flag_q[i] && (upd_idx == IDX_W'(i));
      clr    = clr_en && (clr_idx == IDX_W'(i));
      base_b = clr ? '0 : bytes_q[i];
      base_p = clr ? '0 : pkts_q[i];
      sum_b  = {1'b0, base_b} + BSUM_W'(upd_len);
      sum_p  = {1'b0, base_p} + PSUM_W'(1);
      if (!hit) begin
        bytes_d[i] = base_b;
        pkts_d[i]  = base_p;
      end else begin
        bytes_d[i] = (sum_b > {1'b0, byte_lim}) ? byte_lim : sum_b[BYTE_W-1:0];
        pkts_d[i]  = (sum_p > {1'b0, pkt_lim})  ? pkt_lim  : sum_p[PKT_W-1:0];
      end
      cnt_ce[i] = hit || clr;
      flag_d[i] = (flag_we && (flag_idx == IDX_W'(i))) ? flag_set : flag_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        bytes_q[i] <= '0;
        pkts_q[i]  <= '0;
      end
      flag_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (cnt_ce[i]) begin
          bytes_q[i] <= bytes_d[i];
          pkts_q[i]  <= pkts_d[i];
        end
      end
      if (flag_we) flag_q <= flag_d;
    end
  end

  assign rd_bytes = bytes_q[rd_idx];
  assign rd_pkts  = pkts_q[rd_idx];

  // R6
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !count_en && !clr_en) |=>
      (bytes_q[$past(upd_idx)] == $past(bytes_q[upd_idx])) &&
      (pkts_q[$past(upd_idx)] == $past(pkts_q[upd_idx])));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(upd_valid && (upd_idx == clr_idx))) |=>
      (bytes_q[$past(clr_idx)] == '0) && (pkts_q[$past(clr_idx)] == '0));

  // R8
  clear_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && upd_valid && count_en && flag_q[upd_idx] && (upd_idx == clr_idx)) |=>
      (pkts_q[$past(clr_idx)] == PKT_W'(1)));

endmodule

// File: rtl/flow_read_ctrl.sv
module flow_read_ctrl #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_start,
  input  logic [IDX_W-1:0] ctl_idx,
  output logic             busy,
  output logic             snap_en,
  output logic             pack_en,
  output logic [IDX_W-1:0] idx_q
);

  typedef enum logic [1:0] {RD_IDLE, RD_SNAP, RD_PACK} rd_state_e;

  rd_state_e  state_q;
  rd_state_e  state_d;
  logic       accept;
  logic [IDX_W-1:0] idx_d;

  assign accept = ctl_we && ctl_start && (state_q == RD_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      RD_IDLE: if (accept) begin
        state_d = RD_SNAP;
        idx_d   = ctl_idx;
      end
      RD_SNAP: state_d = RD_PACK;
      RD_PACK: state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) idx_q <= idx_d;
    end
  end

  assign busy    = (state_q != RD_IDLE);
  assign snap_en = (state_q == RD_SNAP);
  assign pack_en = (state_q == RD_PACK);

  // R2
  snap_then_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> pack_en);

  // R2
  pack_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pack_en |=> !busy);

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(idx_q));

endmodule

// File: rtl/flow_result_pack.sv
module flow_result_pack
  import flow_stat_pkg::*;
#(
  parameter int BYTE_W = 64,
  parameter int PKT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_en,
  input  logic              pack_en,
  input  logic              narrow,
  input  logic [BYTE_W-1:0] in_bytes,
  input  logic [PKT_W-1:0]  in_pkts,
  output logic [31:0]       res_w0,
  output logic [31:0]       res_w1,
  output logic [31:0]       res_w2,
  output logic [31:0]       res_w3
);

  logic [63:0] snap_b_q;
  logic [63:0] snap_p_q;
  res_words_t  res_q;
  res_words_t  res_d;

  assign res_d = pack_counts(narrow, snap_b_q, snap_p_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_b_q <= '0;
      snap_p_q <= '0;
    end else if (snap_en) begin
      snap_b_q <= 64'(in_bytes);
      snap_p_q <= 64'(in_pkts);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (pack_en) begin
      res_q <= res_d;
    end
  end

  assign res_w0 = res_q.w0;
  assign res_w1 = res_q.w1;
  assign res_w2 = res_q.w2;
  assign res_w3 = res_q.w3;

  // R5
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pack_en && narrow) |=> (res_w3 == '0) && (res_w2[31:24] == '0));

endmodule

// File: rtl/flow_stat_reader.sv
module flow_stat_reader #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LEN_W   = 16,
  parameter int BYTE_W  = 64,
  parameter int PKT_W   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_count_en,
  input  logic             cfg_read_clear,
  input  logic             cfg_narrow,
  input  logic             flag_we,
  input  logic [IDX_W-1:0] flag_idx,
  input  logic             flag_set,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [LEN_W-1:0] upd_len,
  input  logic             ctl_we,
  input  logic [IDX_W-1:0] ctl_idx,
  input  logic             ctl_start,
  output logic             ctl_busy,
  output logic [31:0]      res_word0,
  output logic [31:0]      res_word1,
  output logic [31:0]      res_word2,
  output logic [31:0]      res_word3
);

  logic             snap_en;
  logic             pack_en;
  logic [IDX_W-1:0] rd_idx;
  logic             clr_en;
  logic [BYTE_W-1:0] rd_bytes;
  logic [PKT_W-1:0]  rd_pkts;

  assign clr_en = snap_en && cfg_read_clear;

  flow_read_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_start (ctl_start),
    .ctl_idx   (ctl_idx),
    .busy      (ctl_busy),
    .snap_en   (snap_en),
    .pack_en   (pack_en),
    .idx_q     (rd_idx)
  );

  flow_cnt_bank #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .LEN_W   (LEN_W),
    .BYTE_W  (BYTE_W),
    .PKT_W   (PKT_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (cfg_count_en),
    .narrow    (cfg_narrow),
    .flag_we   (flag_we),
    .flag_idx  (flag_idx),
    .flag_set  (flag_set),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_len   (upd_len),
    .clr_en    (clr_en),
    .clr_idx   (rd_idx),
    .rd_idx    (rd_idx),
    .rd_bytes  (rd_bytes),
    .rd_pkts   (rd_pkts)
  );

  flow_result_pack #(
    .BYTE_W (BYTE_W),
    .PKT_W  (PKT_W)
  ) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .snap_en  (snap_en),
    .pack_en  (pack_en),
    .narrow   (cfg_narrow),
    .in_bytes (rd_bytes),
    .in_pkts  (rd_pkts),
    .res_w0   (res_word0),
    .res_w1   (res_word1),
    .res_w2   (res_word2),
    .res_w3   (res_word3)
  );

endmodule

// File: tb/test_flow_stat_reader.sv
`timescale 1ns/1ps
module test_flow_stat_reader;

  localparam int ENT  = 8;
  localparam int IW   = 3;
  localparam int LW   = 32;
  localparam int BW   = 36;
  localparam int PW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_count_en = 1'b0;
  logic cfg_read_clear = 1'b0;
  logic cfg_narrow = 1'b0;
  logic flag_we = 1'b0;
  logic [IW-1:0] flag_idx = '0;
  logic flag_set = 1'b0;
  logic upd_valid = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic [LW-1:0] upd_len = '0;
  logic ctl_we = 1'b0;
  logic [IW-1:0] ctl_idx = '0;
  logic ctl_start = 1'b0;
  logic ctl_busy;
  logic [31:0] res_word0, res_word1, res_word2, res_word3;

  int nchecks = 0;
  int nerrors = 0;

  always #2.5 clk = ~clk;

  flow_stat_reader #(
    .ENTRIES(ENT), .IDX_W(IW), .LEN_W(LW), .BYTE_W(BW), .PKT_W(PW)
  ) i_flow_stat_reader (
    .clk(clk), .rst_n(rst_n),
    .cfg_count_en(cfg_count_en), .cfg_read_clear(cfg_read_clear),
    .cfg_narrow(cfg_narrow),
    .flag_we(flag_we), .flag_idx(flag_idx), .flag_set(flag_set),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_len(upd_len),
    .ctl_we(ctl_we), .ctl_idx(ctl_idx), .ctl_start(ctl_start),
    .ctl_busy(ctl_busy),
    .res_word0(res_word0), .res_word1(res_word1),
    .res_word2(res_word2), .res_word3(res_word3)
  );

  function automatic longint unsigned lim_n(input int n);
    if (n >= 64) return 64'hFFFF_FFFF_FFFF_FFFF;
    return (64'd1 << n) - 64'd1;
  endfunction

  // expected words from byte / packet values and layout
  function automatic logic [127:0] exp_words(input logic nar,
                                             input longint unsigned b,
                                             input longint unsigned p);
    longint unsigned cb, cp;
    logic [31:0] w0, w1, w2, w3;
    if (nar) begin
      cb = (b > lim_n(48)) ? lim_n(48) : b;
      cp = (p > lim_n(40)) ? lim_n(40) : p;
      w0 = cb[31:0];
      w1 = {cp[15:0], cb[47:32]};
      w2 = {8'h00, cp[39:16]};
      w3 = 32'h0;
    end else begin
      w0 = b[31:0]; w1 = b[63:32]; w2 = p[31:0]; w3 = p[63:32];
    end
    return {w3, w2, w1, w0};
  endfunction

  // behavioural reference model
  longint unsigned mb [ENT];
  longint unsigned mp [ENT];
  bit              mf [ENT];
  int              mph;
  int              mi;
  longint unsigned sb, sp;
  logic [127:0]    mw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin mb[i] = 0; mp[i] = 0; mf[i] = 0; end
      mph = 0; mi = 0; sb = 0; sp = 0; mw = '0;
    end else begin
      longint unsigned lb, lp, nb, np;
      bit hit;
      lb = lim_n(cfg_narrow ? ((BW < 48) ? BW : 48) : BW);
      lp = lim_n(cfg_narrow ? ((PW < 40) ? PW : 40) : PW);
      hit = upd_valid && cfg_count_en && mf[upd_idx];
      if (mph == 2) mw = exp_words(cfg_narrow, sb, sp);
      if (mph == 1) begin
        sb = mb[mi]; sp = mp[mi];
        if (cfg_read_clear) begin mb[mi] = 0; mp[mi] = 0; end
      end
      if (hit) begin
        nb = mb[upd_idx] + longint'(upd_len);
        np = mp[upd_idx] + 1;
        mb[upd_idx] = (nb > lb) ? lb : nb;
        mp[upd_idx] = (np > lp) ? lp : np;
      end
      if (flag_we) mf[flag_idx] = flag_set;
      if (mph == 0) begin
        if (ctl_we && ctl_start) begin mph = 1; mi = int'(ctl_idx); end
      end else if (mph == 1) mph = 2;
      else mph = 0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "busy vs model", 64'(ctl_busy), 64'(mph != 0));
      chk(cfg_narrow ? "R5" : "R4", "words vs model",
          64'({res_word3, res_word2, res_word1, res_word0} != mw), 64'd0);
    end
  end

  task automatic upd(input int idx, input longint unsigned len);
    upd_valid = 1'b1; upd_idx = IW'(idx); upd_len = LW'(len);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic set_flag(input int idx, input bit v);
    flag_we = 1'b1; flag_idx = IW'(idx); flag_set = v;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  task automatic rd(input int idx, input longint unsigned eb, input longint unsigned ep,
                    input string req, input int intr_idx, input longint coll_len);
    logic [127:0] ew;
    ctl_we = 1'b1; ctl_start = 1'b1; ctl_idx = IW'(idx);
    @(negedge clk);
    ctl_we = 1'b0; ctl_start = 1'b0;
    chk("R2", "busy after accept", 64'(ctl_busy), 64'd1);
    if (intr_idx >= 0) begin
      ctl_we = 1'b1; ctl_start = 1'b1; ctl_idx = IW'(intr_idx);
    end
    if (coll_len >= 0) begin
      upd_valid = 1'b1; upd_idx = IW'(idx); upd_len = LW'(coll_len);
    end
    @(negedge clk);
    ctl_we = 1'b0; ctl_start = 1'b0; upd_valid = 1'b0;
    chk("R2", "busy second cycle", 64'(ctl_busy), 64'd1);
    @(negedge clk);
    chk("R2", "busy cleared", 64'(ctl_busy), 64'd0);
    ew = exp_words(cfg_narrow, eb, ep);
    chk(req, "word0", 64'(res_word0), 64'(ew[31:0]));
    chk(req, "word1", 64'(res_word1), 64'(ew[63:32]));
    chk(req, "word2", 64'(res_word2), 64'(ew[95:64]));
    chk(req, "word3", 64'(res_word3), 64'(ew[127:96]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 64'(ctl_busy), 64'd0);
    chk("R1", "words", 64'(|{res_word0, res_word1, res_word2, res_word3}), 64'd0);
    rd(2, 0, 0, "R1", -1, -1);

    set_flag(2, 1'b1);
    set_flag(5, 1'b1);
    cfg_count_en = 1'b1;
    upd(2, 100);
    upd(2, 200);
    upd(3, 50);
    upd(5, 64'hFFFF_FFFF);
    upd(5, 64'hFFFF_FFFF);
    rd(2, 300, 2, "R6", -1, -1);
    rd(3, 0, 0, "R10", -1, -1);
    rd(5, 64'h1_FFFF_FFFE, 2, "R4", -1, -1);
    cfg_narrow = 1'b1;
    rd(5, 64'h1_FFFF_FFFE, 2, "R5", -1, -1);
    cfg_narrow = 1'b0;

    // counting disabled
    cfg_count_en = 1'b0;
    upd(2, 7);
    rd(2, 300, 2, "R6", -1, -1);
    cfg_count_en = 1'b1;

    // start while busy is ignored
    rd(5, 64'h1_FFFF_FFFE, 2, "R3", 2, -1);
    ctl_we = 1'b1; ctl_start = 1'b0; ctl_idx = 3'd2;
    @(negedge clk);
    ctl_we = 1'b0;
    chk("R3", "no start without start bit", 64'(ctl_busy), 64'd0);

    // read-clear
    cfg_read_clear = 1'b1;
    rd(2, 300, 2, "R7", -1, -1);
    rd(2, 0, 0, "R7", -1, -1);

    // update colliding with the clearing capture
    rd(5, 64'h1_FFFF_FFFE, 2, "R8", -1, 9);
    rd(5, 9, 1, "R8", -1, -1);
    cfg_read_clear = 1'b0;

    // saturation
    for (int k = 0; k < 70; k++) upd(5, 64'hFFFF_FFFF);
    rd(5, 64'hF_FFFF_FFFF, 63, "R9", -1, -1);
    cfg_narrow = 1'b1;
    rd(5, 64'hF_FFFF_FFFF, 63, "R9", -1, -1);
    cfg_narrow = 1'b0;

    // flag cleared
    set_flag(5, 1'b0);
    upd(5, 1);
    rd(5, 64'hF_FFFF_FFFF, 63, "R10", -1, -1);
    upd(2, 11);
    rd(2, 11, 1, "R10", -1, -1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

endmodule